// File: doc/BRIEF.md
# Phase-Correct Dual-Channel PWM Timer

This block produces two pulse-width-modulated outputs from one shared up/down counter. The counter climbs from zero to its ceiling value TOP, turns, and descends back to zero, so each PWM edge falls symmetrically about the ends of the count. The counter advances on an internal tick. A 3-bit clock-select input picks that tick: stopped, every clock, or gated by an external tick-enable strobe from an outside prescaler.

Each channel has a compare value and a 2-bit output mode. Software writes a compare value over a small register bus into a holding register. The counter only uses the value after it is copied into the active compare register, and that copy happens when the count reaches TOP. A write at any point in the period therefore cannot shorten or split a pulse. Reads return the holding register, which is always the value written last. Compare values of zero and TOP produce fixed levels. When the tick is prescaled, a compare value of TOP produces a pulse one full period long.

Top module: `pwm_phase_timer`

## Requirements
- R1: The count steps 0, 1, … TOP, TOP-1, … 0, 1, … on each tick. TOP is all ones of the counter width (0x3FF by default). Each end value is held for exactly one tick, and after reset the first step is upward.
- R2: Clock select 000 freezes the count, 001 ticks on every clock, and any code from 010 to 111 ticks only on clocks where tickEn is high.
- R3: A write with regAddr 0 (channel A) or 1 (channel B) stores the low counter-width bits of regWdata in that channel's holding register. regRdata returns the holding register of the channel selected by regAddr, zero-extended, with no delay.
- R4: The active compare value is loaded from the holding register only at the clock edge where the count becomes TOP. Until that edge, the outputs follow the previous active value.
- R5: Modes 00 and 01 disconnect a channel: one clock later its pwm output and its drive-enable output are both low.
- R6: Mode 10 drives the output low when an upward tick lands the count on the compare value and high when a downward tick does. The output register changes on the edge that takes that tick, and the drive-enable output is high one clock after mode 10 or 11 is applied.
- R7: Mode 11 drives the output high on an upward-tick match and low on a downward-tick match.
- R8: With a compare value of 0, the match (count reaching 0) drives the output low in mode 10 and high in mode 11.
- R9: With clock select 001 and a compare value of TOP, the match at TOP drives the output high in mode 10 and low in mode 11.
- R10: With a prescaled tick (clock select 010 to 111) and a compare value of TOP, successive matches at TOP alternate. The first drives the level of R9, the next drives the opposite level, and so on, giving pulses one full counter period long. A non-TOP match or disconnection restarts the alternation.
- R11: Reset makes the count 0, the direction upward, all holding and active compare values 0, and both pwm and drive-enable outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSel | input | 3 | Tick source select |
| tickEn | input | 1 | External prescaled tick strobe |
| modeA | input | 2 | Channel A output mode |
| modeB | input | 2 | Channel B output mode |
| regWe | input | 1 | Compare register write strobe |
| regAddr | input | 1 | Channel select for write and read |
| regWdata | input | BUS_W | Write data |
| regRdata | output | BUS_W | Holding register of the selected channel |
| count | output | CNT_W | Current counter value |
| pwmA | output | 1 | Channel A PWM level |
| pwmB | output | 1 | Channel B PWM level |
| pwmOeA | output | 1 | Channel A drive enable |
| pwmOeB | output | 1 | Channel B drive enable |

## Verification
A wrong direction bit or end-value handling appears on `count` at the next tick, and it moves every later compare match. A premature copy from holding to active compare shows as a pwm edge at the newly written value before the count has passed TOP, so it becomes visible within half a period. The bench compares every output on every clock against a model built from the requirements, sweeping all compare values of a 4-bit counter in both connected modes with direct and prescaled ticks. Any wrong level or stale alternation bit for the TOP case therefore appears at the first match after it arises.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

  // strobes from the counter control to the compare datapath
  typedef struct packed {
    logic tick;       // counter advances on this clock
    logic stepUp;     // direction of the step being taken
    logic reachTop;   // this step lands on TOP
    logic prescaled;  // tick is gated by the external strobe
  } pwmStrobes_t;

  typedef enum logic [1:0] {
    MODE_OFF0 = 2'b00,
    MODE_OFF1 = 2'b01,
    MODE_NORM = 2'b10,
    MODE_INV  = 2'b11
  } pwmMode_e;

  localparam logic [2:0] CS_STOP = 3'd0;
  localparam logic [2:0] CS_FULL = 3'd1;

endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_phase_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       clkSel,
  input  logic             tickEn,
  output pwmStrobes_t      strb,
  output logic [CNT_W-1:0] nextCnt,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP    = '1;
  localparam logic [CNT_W-1:0] BOTTOM = '0;

  logic [CNT_W-1:0] cntQ;
  logic             downQ;
  logic             tickNow;
  logic             stepUp;
  logic             isPrescaled;

  always_comb begin
    isPrescaled = (clkSel != CS_STOP) && (clkSel != CS_FULL);
    tickNow     = (clkSel == CS_FULL) || (isPrescaled && tickEn);
    // reverse at either end; each end value lasts a single tick
    if (downQ) stepUp = (cntQ == BOTTOM);
    else       stepUp = (cntQ != TOP);
    nextCnt = stepUp ? cntQ + 1'b1 : cntQ - 1'b1;
  end

  always_comb begin
    strb.tick      = tickNow;
    strb.stepUp    = stepUp;
    strb.reachTop  = tickNow && (nextCnt == TOP);
    strb.prescaled = isPrescaled;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      downQ <= 1'b0;
    end else if (tickNow) begin
      cntQ  <= nextCnt;
      downQ <= !stepUp;
    end
  end

  assign count = cntQ;

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_phase_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobes_t      strb,
  input  logic [CNT_W-1:0] nextCnt,
  input  logic [1:0]       mode,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] holdVal,
  output logic             pwm,
  output logic             oe
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] holdQ;
  logic [CNT_W-1:0] actQ;
  logic [CNT_W-1:0] effCmp;
  logic             outQ, outD;
  logic             flagQ, flagD;
  logic             oeQ;
  logic             hit;
  logic             inv;
  logic             connected;

  always_comb begin
    // at the TOP step the freshly latched value is the one compared
    effCmp    = strb.reachTop ? holdQ : actQ;
    hit       = strb.tick && (nextCnt == effCmp);
    inv       = (mode == MODE_INV);
    connected = (mode == MODE_NORM) || (mode == MODE_INV);
  end

  always_comb begin
    outD  = outQ;
    flagD = flagQ;
    if (!connected) begin
      outD  = 1'b0;
      flagD = 1'b0;
    end else if (hit) begin
      if (effCmp == '0) begin
        outD  = inv;
        flagD = 1'b0;
      end else if (effCmp == TOP && strb.prescaled) begin
        // alternate between the fixed level and its opposite
        outD  = flagQ ? inv : !inv;
        flagD = !flagQ;
      end else if (effCmp == TOP) begin
        outD  = !inv;
        flagD = 1'b0;
      end else begin
        outD  = strb.stepUp ? inv : !inv;
        flagD = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= '0;
      actQ  <= '0;
      outQ  <= 1'b0;
      flagQ <= 1'b0;
      oeQ   <= 1'b0;
    end else begin
      if (wrEn)          holdQ <= wrData;
      if (strb.reachTop) actQ  <= holdQ;
      outQ  <= outD;
      flagQ <= flagD;
      oeQ   <= connected;
    end
  end

  assign holdVal = holdQ;
  assign pwm     = outQ;
  assign oe      = oeQ;

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_phase_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int NUM_CH = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pwmStrobes_t                  strb,
  input  logic [CNT_W-1:0]             nextCnt,
  input  logic [NUM_CH-1:0][1:0]       modes,
  input  logic                         wrEn,
  input  logic [$clog2(NUM_CH)-1:0]    chSel,
  input  logic [CNT_W-1:0]             wrData,
  output logic [CNT_W-1:0]             rdData,
  output logic [NUM_CH-1:0]            pwm,
  output logic [NUM_CH-1:0]            oe
);

  logic [NUM_CH-1:0][CNT_W-1:0] holdAll;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    pwm_chan #(.CNT_W(CNT_W)) uChan (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strb),
      .nextCnt (nextCnt),
      .mode    (modes[g]),
      .wrEn    (wrEn && (chSel == g)),
      .wrData  (wrData),
      .holdVal (holdAll[g]),
      .pwm     (pwm[g]),
      .oe      (oe[g])
    );
  end

  assign rdData = holdAll[chSel];

endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer
  import pwm_phase_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       clkSel,
  input  logic             tickEn,
  input  logic [1:0]       modeA,
  input  logic [1:0]       modeB,
  input  logic             regWe,
  input  logic             regAddr,
  input  logic [BUS_W-1:0] regWdata,
  output logic [BUS_W-1:0] regRdata,
  output logic [CNT_W-1:0] count,
  output logic             pwmA,
  output logic             pwmB,
  output logic             pwmOeA,
  output logic             pwmOeB
);

  localparam int NUM_CH = 2;

  pwmStrobes_t              strb;
  logic [CNT_W-1:0]         nextCnt;
  logic [CNT_W-1:0]         rdHold;
  logic [NUM_CH-1:0]        pwmVec;
  logic [NUM_CH-1:0]        oeVec;
  logic                     unusedHiBits;

  assign unusedHiBits = ^regWdata[BUS_W-1:CNT_W];

  pwm_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .clkSel  (clkSel),
    .tickEn  (tickEn),
    .strb    (strb),
    .nextCnt (nextCnt),
    .count   (count)
  );

  pwm_datapath #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .nextCnt (nextCnt),
    .modes   ({modeB, modeA}),
    .wrEn    (regWe),
    .chSel   (regAddr),
    .wrData  (regWdata[CNT_W-1:0]),
    .rdData  (rdHold),
    .pwm     (pwmVec),
    .oe      (oeVec)
  );

  assign regRdata = BUS_W'(rdHold);
  assign pwmA     = pwmVec[0];
  assign pwmB     = pwmVec[1];
  assign pwmOeA   = oeVec[0];
  assign pwmOeB   = oeVec[1];

endmodule

// File: rtl/pwm_phase_timer_chk.sv
module pwm_phase_timer_chk #(
  parameter int CNT_W = 10,
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       clkSel,
  input logic [1:0]       modeA,
  input logic [1:0]       modeB,
  input logic             regWe,
  input logic             regAddr,
  input logic [BUS_W-1:0] regWdata,
  input logic [BUS_W-1:0] regRdata,
  input logic [CNT_W-1:0] count,
  input logic             pwmA,
  input logic             pwmB,
  input logic             pwmOeA,
  input logic             pwmOeB
);

  localparam logic [CNT_W-1:0] TOP    = '1;
  localparam logic [CNT_W-1:0] TOP_M1 = TOP - 1'b1;

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd0) |=> $stable(count));

  // R1
  top_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == TOP && clkSel == 3'd1) |=> (count == TOP_M1));

  // R1
  bottom_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && clkSel == 3'd1) |=> (count == CNT_W'(1)));

  // R5
  off_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeA[1]) |=> (!pwmA && !pwmOeA));

  // R5
  off_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeB[1]) |=> (!pwmB && !pwmOeB));

  // R3
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !regAddr) |=>
      (regAddr || regRdata == BUS_W'($past(regWdata[CNT_W-1:0]))));

  // R6
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd0 && modeA[1]) |=> $stable(pwmA));

endmodule

bind pwm_phase_timer pwm_phase_timer_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .clkSel   (clkSel),
  .modeA    (modeA),
  .modeB    (modeB),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .count    (count),
  .pwmA     (pwmA),
  .pwmB     (pwmB),
  .pwmOeA   (pwmOeA),
  .pwmOeB   (pwmOeB)
);

// File: tb/sim_pwm_phase_timer.sv
module sim_pwm_phase_timer;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int BUS_W      = 16;
  localparam int TOP        = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [2:0]       clkSel = 3'd0;
  logic             tickEn = 1'b0;
  logic [1:0]       modeA = 2'b00;
  logic [1:0]       modeB = 2'b00;
  logic             regWe = 1'b0;
  logic             regAddr = 1'b0;
  logic [BUS_W-1:0] regWdata = '0;
  logic [BUS_W-1:0] regRdata;
  logic [CNT_W-1:0] count;
  logic             pwmA, pwmB, pwmOeA, pwmOeB;

  int checks = 0;
  int fails  = 0;

  // requirement-level model state
  int eCnt, eDown;
  int eHold[2], eAct[2], eOut[2], eFlag[2], eOe[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_phase_timer #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u0 (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .tickEn(tickEn),
    .modeA(modeA), .modeB(modeB), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .count(count),
    .pwmA(pwmA), .pwmB(pwmB), .pwmOeA(pwmOeA), .pwmOeB(pwmOeB)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string outTag(input int ch, input int m);
    if (m < 2)                         return "R5";
    if (eHold[ch] != eAct[ch])         return "R4";
    if (eAct[ch] == 0)                 return "R8";
    if (eAct[ch] == TOP && clkSel != 1) return "R10";
    if (eAct[ch] == TOP)               return "R9";
    if (m == 3)                        return "R7";
    return "R6";
  endfunction

  // advance the model by one clock using the inputs now applied
  task automatic modelStep();
    int tick, up, nx, rt, eff, hit, inv, m, wrCh;
    tick = (clkSel == 1) || (clkSel >= 2 && tickEn);
    up   = eDown ? (eCnt == 0) : (eCnt != TOP);
    nx   = up ? eCnt + 1 : eCnt - 1;
    rt   = tick && (nx == TOP);
    for (int ch = 0; ch < 2; ch++) begin
      m   = (ch == 0) ? int'(modeA) : int'(modeB);
      // R4: the new compare value is taken only on the step onto TOP
      eff = rt ? eHold[ch] : eAct[ch];
      hit = tick && (nx == eff);
      inv = (m == 3);
      if (m < 2) begin
        eOut[ch] = 0; eFlag[ch] = 0;
      end else if (hit) begin
        if (eff == 0) begin eOut[ch] = inv; eFlag[ch] = 0; end
        else if (eff == TOP && clkSel != 1) begin
          eOut[ch] = eFlag[ch] ? inv : !inv; eFlag[ch] = !eFlag[ch];
        end else if (eff == TOP) begin eOut[ch] = !inv; eFlag[ch] = 0; end
        else begin eOut[ch] = up ? inv : !inv; eFlag[ch] = 0; end
      end
      if (rt) eAct[ch] = eHold[ch];
      eOe[ch] = (m >= 2);
    end
    if (regWe) begin
      wrCh = regAddr;
      eHold[wrCh] = int'(regWdata[CNT_W-1:0]);
    end
    if (tick) begin
      eCnt  = nx;
      eDown = !up;
    end
  endtask

  task automatic compareAll();
    check((clkSel == 1) ? "R1" : "R2", "count", int'(count), eCnt);
    check(outTag(0, int'(modeA)), "pwmA", int'(pwmA), eOut[0]);
    check(outTag(1, int'(modeB)), "pwmB", int'(pwmB), eOut[1]);
    check("R6", "pwmOeA", int'(pwmOeA), eOe[0]);
    check("R6", "pwmOeB", int'(pwmOeB), eOe[1]);
  endtask

  task automatic runCycle();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic writeCmp(input int ch, input int val);
    regWe    = 1'b1;
    regAddr  = ch[0];
    regWdata = 16'hA000 | BUS_W'(val);
    runCycle();
    regWe = 1'b0;
    // R3: immediate readback of the pending value, upper bits dropped
    #1;
    check("R3", "regRdata", int'(regRdata), val);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin : main
    eCnt = 0; eDown = 0;
    for (int ch = 0; ch < 2; ch++) begin
      eHold[ch] = 0; eAct[ch] = 0; eOut[ch] = 0; eFlag[ch] = 0; eOe[ch] = 0;
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "count", int'(count), 0);
    check("R11", "pwmA", int'(pwmA), 0);
    check("R11", "pwmB", int'(pwmB), 0);
    check("R11", "pwmOeA", int'(pwmOeA), 0);
    check("R11", "pwmOeB", int'(pwmOeB), 0);
    check("R11", "regRdata", int'(regRdata), 0);
    rstN = 1'b1;

    // R2: clock select 000 holds the count
    clkSel = 3'd0;
    repeat (10) runCycle();

    // sweep every compare value, both connected modes, direct and prescaled ticks
    for (int cs = 1; cs <= 2; cs++) begin
      for (int m = 2; m <= 3; m++) begin
        for (int c = 0; c <= TOP; c++) begin
          clkSel = 3'(cs);
          modeA  = 2'(m);
          modeB  = 2'(m ^ 1);
          writeCmp(0, c);
          writeCmp(1, TOP - c);
          for (int k = 0; k < ((cs == 1) ? 70 : 200); k++) begin
            tickEn = (cs != 1) ? ($urandom_range(2) == 0) : 1'b0;
            runCycle();
          end
        end
      end
    end

    // R2: higher clock-select codes also gate on tickEn
    for (int cs = 3; cs <= 7; cs++) begin
      clkSel = 3'(cs);
      for (int k = 0; k < 40; k++) begin
        tickEn = k[0];
        runCycle();
      end
    end

    // R5: disconnected modes force low outputs
    clkSel = 3'd1;
    modeA = 2'b00;
    modeB = 2'b01;
    writeCmp(0, 5);
    repeat (40) runCycle();

    // R2: stop with connected outputs held
    modeA = 2'b10;
    modeB = 2'b11;
    repeat (40) runCycle();
    clkSel = 3'd0;
    repeat (15) runCycle();

    finishRun();
  end

endmodule